// File: doc/BRIEF.md
# Hot-plug interrupt locator aggregator

This block collects hot-plug events from up to 31 slots, together with a command-completion flag, into one 32-bit locator word and one interrupt request. Each slot has a five-bit event latch and a seven-bit disable byte. A slot raises its locator bit when any latched event has its disable bit clear. The slot at index `s` owns locator bit `s+1`, and bit 0 belongs to command completion. A global control word holds the interrupt-disable bits and two detected flags.

The interrupt can leave the block in two ways. With message signalling off, the aggregated level drives a wired interrupt pin. With it on, the wired pin stays low, and the block emits a one-clock message pulse each time the aggregated level differs from the level that was last requested. Event latches are set by external strobes and cleared by write-one-to-clear strobes from the register interface, which sits outside this block. All inputs and outputs are plain control and status pins. The block has no streamed data, so no valid/ready handshake exists and no back-pressure applies.

Top module: `hpl_locator_agg`

## Requirements
- R1: A slot's latch takes the bits of its strobe group `evt_set[s*5 +: 5]`, with presence at bit 0, isolated power fault at bit 1, attention button at bit 2, MRL change at bit 3 and connected power fault at bit 4. If a bit is set and cleared in the same cycle, the set wins.
- R2: `latch_clr_we` clears the latch bits of slot `latch_clr_slot` wherever `latch_clr_bits` holds a 1. Zero bits leave the latch unchanged.
- R3: Locator bit `s+1` is 1 when `latch & ~disable[4:0]` is nonzero for slot `s`. Disable bits 5 and 6 do not affect the locator. `dis_we` loads `dis_val` into the disable byte of slot `dis_slot`.
- R4: Locator bit 0 equals the command-detected flag (control bit 16) AND NOT command-interrupt-disable (control bit 2). `cmd_done` sets the flag.
- R5: In the control word, bits [3:0] are written directly by `ctl_we`. Bits 16 (command detected) and 17 (arbiter detected) are set by `cmd_done` and `arb_detect` and cleared by writing 1. A set in the same cycle as a clear wins. All other bits read 0.
- R6: The aggregated level is 1 only when control bit 0 (global interrupt disable) is clear and the locator is nonzero.
- R7: After reset all latches are 0, every disable byte is 7'h7F, and the control word is 32'h0000000F.
- R8: `irq_wire` carries the aggregated level while `msg_en` is 0, and is 0 while `msg_en` is 1.
- R9: The requested level follows the aggregated level one cycle behind. `msg_pulse` is high for exactly one cycle after any cycle in which `msg_en` was 1 and the aggregated level differed from the requested level. Both rising and falling changes produce a pulse.
- R10: Locator bits above `N_SLOTS` read 0. Clear and disable writes that name a slot index at or above `N_SLOTS` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_en | input | 1 | Message signalling enabled |
| evt_set | input | N_SLOTS*5 | Per-slot event set strobes |
| latch_clr_we | input | 1 | Latch write-one-to-clear strobe |
| latch_clr_slot | input | 5 | Slot index for latch clear |
| latch_clr_bits | input | 5 | Bits to clear |
| dis_we | input | 1 | Disable byte write strobe |
| dis_slot | input | 5 | Slot index for disable write |
| dis_val | input | 7 | New disable byte |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| cmd_done | input | 1 | Command completed, sets bit 16 |
| arb_detect | input | 1 | Arbiter event, sets bit 17 |
| locator | output | 32 | Interrupt locator word |
| ctl_word | output | 32 | Current control word |
| irq_wire | output | 1 | Wired level interrupt |
| msg_pulse | output | 1 | One-cycle message request |

## Verification
The bench targets the cases where a set and a clear of the same latch bit or control flag arrive in one cycle. A design that gives priority to the clear would lose the event, so the locator bit or flag would read 0. It also writes disable bytes that mask only the high bits 5 and 6, and sends clear and disable writes to slot indices above the slot count. A design that decoded these wrongly would either drop a live slot bit or let a phantom slot corrupt the locator. In message mode it drives the level both up and down and checks for a single pulse one cycle later each time. A design that signalled only on a rise, held the pulse for several cycles, or also drove the wired pin would fail those checks.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
  localparam int MAX_SLOTS = 31;
  localparam int IDX_W     = 5;
  localparam int EVT_W     = 5;
  localparam int DIS_W     = 7;
  localparam int LOC_W     = 32;
  localparam int CFG_W     = 4;

  localparam logic [DIS_W-1:0] DIS_RST = '1;
  localparam logic [CFG_W-1:0] CFG_RST = 4'hF;

  // control word bit positions
  localparam int B_INT_DIS     = 0;
  localparam int B_CMD_INT_DIS = 2;
  localparam int B_CMD_DET     = 16;
  localparam int B_ARB_DET     = 17;
endpackage

// File: rtl/hpl_slot_bank.sv
module hpl_slot_bank
  import hpl_pkg::*;
#(
  parameter int N_SLOTS = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SLOTS*EVT_W-1:0] evt_set,
  input  logic                     latch_clr_we,
  input  logic [IDX_W-1:0]         latch_clr_slot,
  input  logic [EVT_W-1:0]         latch_clr_bits,
  input  logic                     dis_we,
  input  logic [IDX_W-1:0]         dis_slot,
  input  logic [DIS_W-1:0]         dis_val,
  output logic [N_SLOTS-1:0]       slot_hit
);
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [EVT_W-1:0] latch_q;
    logic [DIS_W-1:0] dis_q;
    logic [EVT_W-1:0] clr_mask;
    logic             dis_sel;
    logic             unused_hi;

    assign clr_mask  = (latch_clr_we && latch_clr_slot == IDX_W'(s)) ? latch_clr_bits : '0;
    assign dis_sel   = dis_we && (dis_slot == IDX_W'(s));
    assign unused_hi = ^dis_q[DIS_W-1:EVT_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q <= '0;
        dis_q   <= DIS_RST;
      end else begin
        // clear first, then set: a simultaneous event is kept
        latch_q <= (latch_q & ~clr_mask) | evt_set[s*EVT_W +: EVT_W];
        if (dis_sel) dis_q <= dis_val;
      end
    end

    assign slot_hit[s] = |(latch_q & ~dis_q[EVT_W-1:0]);
  end
endmodule

// File: rtl/hpl_ctl_reg.sv
module hpl_ctl_reg
  import hpl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [LOC_W-1:0] ctl_wdata,
  input  logic             cmd_done,
  input  logic             arb_detect,
  output logic [LOC_W-1:0] ctl_word
);
  logic [CFG_W-1:0] cfg_q;
  logic             cmd_q;
  logic             arb_q;
  logic             unused_wd;

  assign unused_wd = ^{ctl_wdata[LOC_W-1:B_ARB_DET+1], ctl_wdata[B_CMD_DET-1:CFG_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      cmd_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      if (ctl_we) cfg_q <= ctl_wdata[CFG_W-1:0];
      cmd_q <= (cmd_q & ~(ctl_we & ctl_wdata[B_CMD_DET])) | cmd_done;
      arb_q <= (arb_q & ~(ctl_we & ctl_wdata[B_ARB_DET])) | arb_detect;
    end
  end

  always_comb begin
    ctl_word            = '0;
    ctl_word[CFG_W-1:0] = cfg_q;
    ctl_word[B_CMD_DET] = cmd_q;
    ctl_word[B_ARB_DET] = arb_q;
  end
endmodule

// File: rtl/hpl_loc_build.sv
module hpl_loc_build
  import hpl_pkg::*;
#(
  parameter int N_SLOTS = 31
) (
  input  logic [N_SLOTS-1:0] slot_hit,
  input  logic               cmd_det,
  input  logic               cmd_int_dis,
  output logic [LOC_W-1:0]   locator
);
  assign locator[0] = cmd_det & ~cmd_int_dis;

  for (genvar b = 1; b < LOC_W; b++) begin : g_bit
    if (b <= N_SLOTS) begin : g_on
      assign locator[b] = slot_hit[b-1];
    end else begin : g_off
      assign locator[b] = 1'b0;
    end
  end
endmodule

// File: rtl/hpl_irq_out.sv
module hpl_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic msg_en,
  output logic irq_wire,
  output logic msg_pulse
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      msg_pulse <= 1'b0;
    end else begin
      msg_pulse <= msg_en & (level ^ req_q);
      req_q     <= level;
    end
  end

  assign irq_wire = level & ~msg_en;
endmodule

// File: rtl/hpl_locator_agg.sv
module hpl_locator_agg
  import hpl_pkg::*;
#(
  parameter int N_SLOTS = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     msg_en,
  input  logic [N_SLOTS*EVT_W-1:0] evt_set,
  input  logic                     latch_clr_we,
  input  logic [IDX_W-1:0]         latch_clr_slot,
  input  logic [EVT_W-1:0]         latch_clr_bits,
  input  logic                     dis_we,
  input  logic [IDX_W-1:0]         dis_slot,
  input  logic [DIS_W-1:0]         dis_val,
  input  logic                     ctl_we,
  input  logic [LOC_W-1:0]         ctl_wdata,
  input  logic                     cmd_done,
  input  logic                     arb_detect,
  output logic [LOC_W-1:0]         locator,
  output logic [LOC_W-1:0]         ctl_word,
  output logic                     irq_wire,
  output logic                     msg_pulse
);
  logic [N_SLOTS-1:0] slot_hit;
  logic               level;

  hpl_slot_bank #(.N_SLOTS(N_SLOTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .latch_clr_we(latch_clr_we), .latch_clr_slot(latch_clr_slot),
    .latch_clr_bits(latch_clr_bits), .dis_we(dis_we), .dis_slot(dis_slot),
    .dis_val(dis_val), .slot_hit(slot_hit)
  );

  hpl_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_done(cmd_done), .arb_detect(arb_detect), .ctl_word(ctl_word)
  );

  hpl_loc_build #(.N_SLOTS(N_SLOTS)) u_loc (
    .slot_hit(slot_hit), .cmd_det(ctl_word[B_CMD_DET]),
    .cmd_int_dis(ctl_word[B_CMD_INT_DIS]), .locator(locator)
  );

  assign level = ~ctl_word[B_INT_DIS] & (|locator);

  hpl_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .level(level), .msg_en(msg_en),
    .irq_wire(irq_wire), .msg_pulse(msg_pulse)
  );
endmodule

// File: rtl/hpl_locator_agg_chk.sv
module hpl_locator_agg_chk #(
  parameter int N_SLOTS = 31
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_en,
  input logic        cmd_done,
  input logic [31:0] locator,
  input logic [31:0] ctl_word,
  input logic        irq_wire,
  input logic        msg_pulse
);
  assert_wire_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wire |-> (!ctl_word[0] && locator != 32'h0));

  assert_wire_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_en |-> !irq_wire);

  assert_pulse_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> $past(msg_en));

  assert_ctl_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word & ~32'h0003_000F) == 32'h0);

  assert_cmd_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_word[16]) |-> $past(cmd_done));

  assert_high_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (64'(locator) >> (N_SLOTS + 1)) == 64'h0);
endmodule

bind hpl_locator_agg hpl_locator_agg_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .cmd_done(cmd_done),
  .locator(locator), .ctl_word(ctl_word), .irq_wire(irq_wire),
  .msg_pulse(msg_pulse)
);

// File: tb/hpl_locator_agg_test.sv
module hpl_locator_agg_test;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          msg_en = 1'b0;
  logic [N*5-1:0] s_ev = '0;
  logic          s_lcwe = 1'b0;
  logic [4:0]    s_lcslot = '0;
  logic [4:0]    s_lcbits = '0;
  logic          s_dwe = 1'b0;
  logic [4:0]    s_dslot = '0;
  logic [6:0]    s_dval = '0;
  logic          s_cwe = 1'b0;
  logic [31:0]   s_cwd = '0;
  logic          s_cd = 1'b0;
  logic          s_ad = 1'b0;
  logic          nxt_me = 1'b0;

  logic [31:0] locator, ctl_word;
  logic        irq_wire, msg_pulse;

  hpl_locator_agg #(.N_SLOTS(N)) uut (
    .clk(clk), .rst_n(rst_n), .msg_en(msg_en), .evt_set(s_ev),
    .latch_clr_we(s_lcwe), .latch_clr_slot(s_lcslot), .latch_clr_bits(s_lcbits),
    .dis_we(s_dwe), .dis_slot(s_dslot), .dis_val(s_dval),
    .ctl_we(s_cwe), .ctl_wdata(s_cwd), .cmd_done(s_cd), .arb_detect(s_ad),
    .locator(locator), .ctl_word(ctl_word), .irq_wire(irq_wire),
    .msg_pulse(msg_pulse)
  );

  typedef struct {
    string       tag;
    logic [31:0] loc;
    logic        irq;
    logic        pulse;
    logic [31:0] ctl;
  } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model built from the requirements
  logic [4:0] m_latch[N];
  logic [6:0] m_dis[N];
  logic [3:0] m_cfg = 4'hF;
  logic       m_cmd = 1'b0;
  logic       m_arb = 1'b0;
  logic       m_lvl_prev = 1'b0;
  logic       m_req = 1'b0;

  function automatic logic [31:0] exp_loc();
    logic [31:0] l = '0;
    for (int s = 0; s < N; s++)
      if ((m_latch[s] & ~m_dis[s][4:0]) != 5'h0) l[s+1] = 1'b1;
    l[0] = m_cmd & ~m_cfg[2];
    return l;
  endfunction

  function automatic logic [31:0] exp_ctl();
    return {14'h0, m_arb, m_cmd, 12'h0, m_cfg};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one call per clock edge, pushes the expected result
  task automatic step(string tag);
    exp_t e;
    logic pulse;
    logic lvl;
    @(negedge clk);
    #2;
    msg_en = nxt_me;
    pulse = msg_en & (m_lvl_prev ^ m_req);
    m_req = m_lvl_prev;
    for (int s = 0; s < N; s++) begin
      if (s_lcwe && s_lcslot == 5'(s)) m_latch[s] = m_latch[s] & ~s_lcbits;
      m_latch[s] = m_latch[s] | s_ev[s*5 +: 5];
      if (s_dwe && s_dslot == 5'(s)) m_dis[s] = s_dval;
    end
    if (s_cwe) begin
      m_cfg = s_cwd[3:0];
      if (s_cwd[16]) m_cmd = 1'b0;
      if (s_cwd[17]) m_arb = 1'b0;
    end
    if (s_cd) m_cmd = 1'b1;
    if (s_ad) m_arb = 1'b1;
    @(posedge clk);
    #1;
    s_ev = '0; s_lcwe = 1'b0; s_dwe = 1'b0; s_cwe = 1'b0; s_cd = 1'b0; s_ad = 1'b0;
    lvl = ~m_cfg[0] & (exp_loc() != 32'h0);
    e.tag = tag;
    e.loc = exp_loc();
    e.irq = lvl & ~msg_en;
    e.pulse = pulse;
    e.ctl = exp_ctl();
    sbq.push_back(e);
    m_lvl_prev = lvl;
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        cmp(e.tag, "locator", locator, e.loc);
        cmp(e.tag, "irq_wire", {31'h0, irq_wire}, {31'h0, e.irq});
        cmp(e.tag, "msg_pulse", {31'h0, msg_pulse}, {31'h0, e.pulse});
        cmp(e.tag, "ctl_word", ctl_word, e.ctl);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    for (int s = 0; s < N; s++) begin
      m_latch[s] = '0;
      m_dis[s] = 7'h7F;
    end
    repeat (3) @(posedge clk);
    #1;
    r.tag = "R7 reset state"; r.loc = '0; r.irq = 1'b0; r.pulse = 1'b0; r.ctl = 32'h0000000F;
    sbq.push_back(r);
    @(negedge clk);
    #2 rst_n = 1'b1;

    s_ev[0] = 1'b1;                                  step("R7 R3 presence masked by reset disable");
    s_dwe = 1; s_dslot = 0; s_dval = 7'h60;          step("R3 high disable bits ignored, slot0 at bit1");
    s_cwe = 1; s_cwd = 32'h0;                        step("R6 global enable raises level");
    s_ev[4*5+2] = 1'b1; s_dwe = 1; s_dslot = 4; s_dval = 7'h7B;
                                                     step("R1 R10 button event on last slot at bit5");
    s_lcwe = 1; s_lcslot = 0; s_lcbits = 5'h1E;      step("R2 zero clear bits keep latch");
    s_lcwe = 1; s_lcslot = 0; s_lcbits = 5'h01; s_ev[0] = 1'b1;
                                                     step("R1 set wins over clear");
    s_lcwe = 1; s_lcslot = 0; s_lcbits = 5'h01;      step("R2 write one clears presence");
    s_lcwe = 1; s_lcslot = 7; s_lcbits = 5'h1F; s_dwe = 1; s_dslot = 7; s_dval = 7'h00;
                                                     step("R10 out of range slot ignored");
    s_cd = 1'b1;                                     step("R4 command completion at bit0");
    s_cwe = 1; s_cwd = 32'h4;                        step("R4 command interrupt disable masks bit0");
    s_ad = 1'b1;                                     step("R5 arbiter flag set");
    s_cwe = 1; s_cwd = 32'h0003_0001;                step("R5 R6 flags cleared and global disable");
    s_cwe = 1; s_cwd = 32'h0001_0000; s_cd = 1'b1;   step("R5 set wins over write one clear");
    nxt_me = 1'b1;                                   step("R8 message mode silences wire");
    s_lcwe = 1; s_lcslot = 4; s_lcbits = 5'h1F; s_cwe = 1; s_cwd = 32'h0001_0000;
                                                     step("R9 level falls");
    step("R9 pulse after fall");
    step("R9 pulse one cycle wide");
    s_ev[1*5+3] = 1'b1; s_dwe = 1; s_dslot = 1; s_dval = 7'h00;
                                                     step("R1 R9 MRL event raises level");
    step("R9 pulse after rise");
    step("R9 no pulse at steady level");
    nxt_me = 1'b0;                                   step("R8 wire returns with message mode off");
    s_ev[2*5+1] = 1'b1; s_ev[2*5+4] = 1'b1; s_dwe = 1; s_dslot = 2; s_dval = 7'h6D;
                                                     step("R1 R3 fault bits on slot2 at bit3");

    repeat (2) @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule